// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a bank of small control registers for a workstation I/O controller. It holds seven registers:

- an 8-bit configuration register;
- an 8-bit diagnostic scratch register;
- an 8-bit modem-control register;
- an 8-bit auxiliary-function register;
- an 8-bit power-down register;
- a 16-bit LED register;
- a 32-bit system-control word.

A simple synchronous bus reaches the registers. Each cycle it offers one register select, an access width, an offset, a write or read strobe and write data. Read data returns one cycle later.

Several registers have side effects:

- **Auxiliary-function register.** Writing it with bit 1 set fires a one-cycle floppy terminal-count strobe.
- **Power-down register.** It drives a power-off request. It holds the power-fail status bit, which software clears by writing one to the clear bit.
- **System-control word.** Writing it with bit 0 set asks for a system reset. It also leaves a sticky reset-status flag. Reset does not clear this flag, so software can see it after the reset.

A power-failing input passes through a synchronizer. A two-state machine then follows it:

- `PF_CLEAR` goes to `PF_LATCHED` when a change of the synchronized level is seen, the level is high and the interrupt enable is set.
- `PF_LATCHED` goes back to `PF_CLEAR` on a clear write, or on a change seen while the level is low or the enable is off.
- With no event and no clear write, the machine keeps its state.

The power-fail interrupt is the AND of that status and the enable.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pf_irq` is high exactly when configuration bit 3 (interrupt enable) and the power-fail status (power-down bit 5) are both set. Changing the enable alone moves `pf_irq` at once and leaves the status unchanged.
- R2: `pf_in` passes two synchronizer flops. On the third rising edge after `pf_in` changes, the status becomes 1 if the synchronized level is 1 and the enable is set; otherwise it becomes 0. With no level change, the status holds.
- R3: An accepted write to the auxiliary-function register stores every written bit except bit 1, which always reads back 0. If bit 1 was written as 1, `tc_pulse` is high for exactly the next cycle.
- R4: An accepted write to the power-down register stores only bit 0. Writing bit 1 as 1 clears the status, and bit 1 is never stored. Otherwise the write keeps the status. The read value is {status at bit 5, power-off at bit 0}.
- R5: `pwr_off_req` equals the stored power-down bit 0.
- R6: An accepted system-control write with bit 0 set loads the register with 0x02 and makes `sys_reset_req` high for the next cycle. A write with bit 0 clear changes nothing.
- R7: A synchronous reset (`rst_n` low at a clock edge) clears configuration, auxiliary-function, power-down (including the status) and modem-control registers. It leaves the diagnostic, LED and system-control registers unchanged.
- R8: The select codes are 0 configuration, 1 diagnostic, 2 modem, 3 auxiliary, 4 power-down, 5 LED and 6 system-control; code 7 selects nothing. The width codes are 0 byte, 1 halfword, 2 word and 3 reserved. The LED register needs a halfword, system control needs a word, and all others need a byte.
- R9: An access with the wrong width to a select of 0 to 6 writes nothing and reads 0. It makes `size_err` high for exactly the next cycle.
- R10: An access with the correct width but a non-zero offset writes nothing, reads 0 and raises no error.
- R11: `rdata` shows the selected value in the cycle after `rd_en`. It is 0 in a cycle that follows no read, and it is 0 for select 7.
- R12: At power-on the diagnostic, LED and system-control registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_in | input | 1 | Asynchronous power-failing line |
| reg_sel | input | 3 | Register select code |
| acc_size | input | 2 | Access width code |
| acc_off | input | 2 | Byte offset within the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count strobe |
| pwr_off_req | output | 1 | Power-off request level |
| sys_reset_req | output | 1 | System-reset request strobe |
| size_err | output | 1 | Wrong-width access strobe |

## Verification
A status machine left in the wrong state shows on `pf_irq` in the same cycle, provided the enable is set. It also shows on the next power-down read, as a wrong bit 5. A wrong decode or stored value shows up only when that register is read back, one cycle after the read strobe. The bench reads registers often so that such errors appear within a few cycles.

A missing or stretched strobe differs from the reference model in the very cycle after the triggering write. The bench therefore compares every output against its model in every cycle. It toggles `pf_in` around enable changes, clear writes and resets, so that a wrong synchronizer depth or a wrong event priority shows up as a status difference on the third edge.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int NUM_REGS = 7;

    typedef enum logic [2:0] {
        SEL_CFG    = 3'd0,
        SEL_DIAG   = 3'd1,
        SEL_MODEM  = 3'd2,
        SEL_AUXF   = 3'd3,
        SEL_PDOWN  = 3'd4,
        SEL_LED    = 3'd5,
        SEL_SYSCTL = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        PF_CLEAR   = 1'b0,
        PF_LATCHED = 1'b1
    } pf_state_e;

    localparam int CFG_PFEN_BIT  = 3;
    localparam int AUXF_TC_BIT   = 1;
    localparam int PD_OFF_BIT    = 0;
    localparam int PD_CLR_BIT    = 1;
    localparam int PD_STAT_BIT   = 5;
    localparam int SYS_RST_BIT   = 0;
    localparam logic [7:0] SYS_RST_FLAG = 8'h02;

    // required access width for each select code
    function automatic logic [1:0] size_for(input logic [2:0] sel);
        case (sel)
            3'd5:    size_for = SZ_HALF;
            3'd6:    size_for = SZ_WORD;
            default: size_for = SZ_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aux_access_dec.sv
module aux_access_dec
    import aux_sysctl_pkg::*;
(
    input  logic [2:0]          reg_sel,
    input  logic [1:0]          acc_size,
    input  logic [1:0]          acc_off,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit,
    output logic                size_bad
);
    genvar i;
    generate
        for (i = 0; i < NUM_REGS; i++) begin : g_reg
            logic match;
            assign match     = (reg_sel == 3'(i)) && (acc_size == size_for(3'(i)))
                               && (acc_off == 2'd0);
            assign wr_hit[i] = wr_en && match;
            assign rd_hit[i] = rd_en && match;
        end
    endgenerate

    assign size_bad = (wr_en || rd_en) && (reg_sel != SEL_NONE)
                      && (acc_size != size_for(reg_sel));
endmodule

// File: rtl/aux_pf_fsm.sv
module aux_pf_fsm
    import aux_sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic clr_wr,
    output logic status
);
    pf_state_e state_q, state_d;
    logic      lvl_prev_q;
    logic      evt;

    assign evt = (lvl != lvl_prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PF_CLEAR;
            lvl_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            lvl_prev_q <= lvl;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR:
                if (evt && lvl && en && !clr_wr) state_d = PF_LATCHED;
            PF_LATCHED:
                if (clr_wr || (evt && !(lvl && en))) state_d = PF_CLEAR;
        endcase
    end

    always_comb begin
        status = (state_q == PF_LATCHED);
    end

    // R4
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !status);

    // R2
    set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> ($past(en) && $past(lvl)));
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LED_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_in,
    input  logic [2:0]        reg_sel,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_off,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pf_irq,
    output logic              tc_pulse,
    output logic              pwr_off_req,
    output logic              sys_reset_req,
    output logic              size_err
);
    logic [NUM_REGS-1:0] wr_hit, rd_hit;
    logic                size_bad;
    logic                pf_lvl, pf_status, pd_clr_wr;

    logic [BYTE_W-1:0] cfg_q, modem_q, aux1_q;
    logic              pd_off_q;
    logic [BYTE_W-1:0] diag_q   = '0;
    logic [LED_W-1:0]  led_q    = '0;
    logic [BYTE_W-1:0] sysctl_q = '0;
    logic [DATA_W-1:0] rd_val, rdata_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:LED_W];

    aux_access_dec u_dec (
        .reg_sel  (reg_sel),
        .acc_size (acc_size),
        .acc_off  (acc_off),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit),
        .size_bad (size_bad)
    );

    aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pf_in),
        .q     (pf_lvl)
    );

    assign pd_clr_wr = wr_hit[SEL_PDOWN] && wdata[PD_CLR_BIT];

    aux_pf_fsm u_pf (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (pf_lvl),
        .en     (cfg_q[CFG_PFEN_BIT]),
        .clr_wr (pd_clr_wr),
        .status (pf_status)
    );

    // registers cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            modem_q  <= '0;
            aux1_q   <= '0;
            pd_off_q <= 1'b0;
        end else begin
            if (wr_hit[SEL_CFG])   cfg_q   <= wdata[BYTE_W-1:0];
            if (wr_hit[SEL_MODEM]) modem_q <= wdata[BYTE_W-1:0];
            if (wr_hit[SEL_AUXF]) begin
                aux1_q              <= wdata[BYTE_W-1:0];
                aux1_q[AUXF_TC_BIT] <= 1'b0;
            end
            if (wr_hit[SEL_PDOWN]) pd_off_q <= wdata[PD_OFF_BIT];
        end
    end

    // registers kept across reset
    always_ff @(posedge clk) begin
        if (wr_hit[SEL_DIAG]) diag_q <= wdata[BYTE_W-1:0];
        if (wr_hit[SEL_LED])  led_q  <= wdata[LED_W-1:0];
        if (wr_hit[SEL_SYSCTL] && wdata[SYS_RST_BIT]) sysctl_q <= SYS_RST_FLAG;
    end

    // strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_pulse      <= 1'b0;
            sys_reset_req <= 1'b0;
            size_err      <= 1'b0;
        end else begin
            tc_pulse      <= wr_hit[SEL_AUXF] && wdata[AUXF_TC_BIT];
            sys_reset_req <= wr_hit[SEL_SYSCTL] && wdata[SYS_RST_BIT];
            size_err      <= size_bad;
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_CFG:    rd_val[BYTE_W-1:0] = cfg_q;
            SEL_DIAG:   rd_val[BYTE_W-1:0] = diag_q;
            SEL_MODEM:  rd_val[BYTE_W-1:0] = modem_q;
            SEL_AUXF:   rd_val[BYTE_W-1:0] = aux1_q;
            SEL_PDOWN: begin
                rd_val[PD_STAT_BIT] = pf_status;
                rd_val[PD_OFF_BIT]  = pd_off_q;
            end
            SEL_LED:    rd_val[LED_W-1:0]  = led_q;
            SEL_SYSCTL: rd_val[BYTE_W-1:0] = sysctl_q;
            SEL_NONE:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (|rd_hit)   rdata_q <= rd_val;
        else                rdata_q <= '0;
    end

    assign rdata       = rdata_q;
    assign pf_irq      = cfg_q[CFG_PFEN_BIT] && pf_status;
    assign pwr_off_req = pd_off_q;

    // R6
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> (sysctl_q == SYS_RST_FLAG));

    // R9
    bad_size_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> ($stable(cfg_q) && $stable(aux1_q) && $stable(led_q)));

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == '0));

    // R3
    tc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> ($past(wr_en) && ($past(reg_sel) == SEL_AUXF)));
endmodule

// File: tb/aux_sysctl_regs_tb.sv
`timescale 1ns/1ps
module aux_sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pf_in = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_off = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pf_irq, tc_pulse, pwr_off_req, sys_reset_req, size_err;

    always #2.5 clk = ~clk;

    aux_sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .pf_in(pf_in), .reg_sel(reg_sel),
        .acc_size(acc_size), .acc_off(acc_off), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pf_irq(pf_irq), .tc_pulse(tc_pulse),
        .pwr_off_req(pwr_off_req), .sys_reset_req(sys_reset_req), .size_err(size_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [7:0]  m_cfg = 0, m_diag = 0, m_modem = 0, m_aux1 = 0, m_sys = 0;
    logic [15:0] m_led = 0;
    logic        m_off = 0, m_st = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [31:0] e_rdata = 0;
    logic        e_tc = 0, e_rst = 0, e_err = 0;
    string       e_tag = "R11";

    function automatic logic [1:0] need_size(input logic [2:0] s);
        return (s == 3'd5) ? 2'd1 : (s == 3'd6) ? 2'd2 : 2'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return {24'd0, m_cfg};
            3'd1: return {24'd0, m_diag};
            3'd2: return {24'd0, m_modem};
            3'd3: return {24'd0, m_aux1};
            3'd4: return {26'd0, m_st, 4'd0, m_off};
            3'd5: return {16'd0, m_led};
            3'd6: return {24'd0, m_sys};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic known, szok, wok, rok;
        known = (reg_sel != 3'd7);
        szok  = (acc_size == need_size(reg_sel));
        wok   = wr_en && known && szok && (acc_off == 0);
        rok   = rd_en && known && szok && (acc_off == 0);
        if (!rst_n) begin
            m_cfg = 0; m_modem = 0; m_aux1 = 0; m_off = 0; m_st = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
            e_rdata = 0; e_tc = 0; e_rst = 0; e_err = 0;
        end else begin
            e_rdata = rok ? model_read(reg_sel) : 32'd0;
            if (rd_en && known && !szok)                  e_tag = "R9";
            else if (rd_en && known && acc_off != 0)      e_tag = "R10";
            else if (rd_en && reg_sel == 3'd3)            e_tag = "R3";
            else if (rd_en && reg_sel == 3'd4)            e_tag = "R4";
            else if (rd_en && reg_sel == 3'd6)            e_tag = "R6";
            else                                          e_tag = "R11";
            e_tc  = wok && reg_sel == 3'd3 && wdata[1];
            e_rst = wok && reg_sel == 3'd6 && wdata[0];
            e_err = (wr_en || rd_en) && known && !szok;
            if (m_s2 != m_prev) m_st = m_s2 & m_cfg[3];
            if (wok) begin
                case (reg_sel)
                    3'd0: m_cfg = wdata[7:0];
                    3'd1: m_diag = wdata[7:0];
                    3'd2: m_modem = wdata[7:0];
                    3'd3: m_aux1 = wdata[7:0] & 8'hFD;
                    3'd4: begin
                        if (wdata[1]) m_st = 0;
                        m_off = wdata[0];
                    end
                    3'd5: m_led = wdata[15:0];
                    3'd6: if (wdata[0]) m_sys = 8'h02;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pf_in;
        end
    end

    task automatic check_outputs();
        check("R1 pf_irq", {31'd0, pf_irq}, {31'd0, m_cfg[3] & m_st});
        check("R5 pwr_off_req", {31'd0, pwr_off_req}, {31'd0, m_off});
        check("R3 tc_pulse", {31'd0, tc_pulse}, {31'd0, e_tc});
        check("R6 sys_reset_req", {31'd0, sys_reset_req}, {31'd0, e_rst});
        check("R9 size_err", {31'd0, size_err}, {31'd0, e_err});
        check({e_tag, " rdata"}, rdata, e_rdata);
    endtask

    task automatic cyc(input logic [2:0] s, input logic [1:0] z, input logic [1:0] o,
                       input logic w, input logic r, input logic [31:0] d);
        reg_sel = s; acc_size = z; acc_off = o; wr_en = w; rd_en = r; wdata = d;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(3'd7, 2'd0, 2'd0, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic wr(input logic [2:0] s, input logic [1:0] z, input logic [31:0] d);
        cyc(s, z, 2'd0, 1'b1, 1'b0, d);
    endtask

    task automatic rd(input logic [2:0] s, input logic [1:0] z);
        cyc(s, z, 2'd0, 1'b0, 1'b1, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        check("R7 reset irq", {31'd0, pf_irq}, 32'd0);
        check("R7 reset pwr_off", {31'd0, pwr_off_req}, 32'd0);
        rd(3'd1, 2'd0); check("R12 diag power-on", rdata, 32'd0);
        rd(3'd5, 2'd1); check("R12 led power-on", rdata, 32'd0);
        rd(3'd6, 2'd2); check("R12 sysctl power-on", rdata, 32'd0);

        // R8 widths
        wr(3'd0, 2'd0, 32'h08); rd(3'd0, 2'd0); check("R8 cfg byte", rdata, 32'h08);
        wr(3'd5, 2'd1, 32'h1234BEEF); rd(3'd5, 2'd1); check("R8 led half", rdata, 32'hBEEF);
        wr(3'd5, 2'd0, 32'h1111); check("R9 err strobe", {31'd0, size_err}, 32'd1);
        idle(1); check("R9 err one cycle", {31'd0, size_err}, 32'd0);
        rd(3'd5, 2'd0); check("R9 bad read zero", rdata, 32'd0);
        rd(3'd5, 2'd1); check("R9 led unchanged", rdata, 32'hBEEF);

        // R2 power-fail with enable set
        pf_in = 1'b1;
        idle(2); check("R2 not yet latched", {31'd0, pf_irq}, 32'd0);
        idle(1); check("R2 latched third edge", {31'd0, pf_irq}, 32'd1);
        rd(3'd4, 2'd0); check("R2 status read", rdata, 32'h20);
        // R1 enable off hides irq, keeps status
        wr(3'd0, 2'd0, 32'h00); check("R1 irq off", {31'd0, pf_irq}, 32'd0);
        rd(3'd4, 2'd0); check("R1 status kept", rdata, 32'h20);
        wr(3'd0, 2'd0, 32'h08); check("R1 irq back", {31'd0, pf_irq}, 32'd1);
        // R4 write keeps status, then clear
        wr(3'd4, 2'd0, 32'hFD); rd(3'd4, 2'd0); check("R4 keep status", rdata, 32'h21);
        check("R5 power off", {31'd0, pwr_off_req}, 32'd1);
        wr(3'd4, 2'd0, 32'h02); rd(3'd4, 2'd0); check("R4 clear status", rdata, 32'h00);
        check("R4 irq cleared", {31'd0, pf_irq}, 32'd0);
        // R2 disabled: no latch
        wr(3'd0, 2'd0, 32'h00);
        pf_in = 1'b0; idle(4); pf_in = 1'b1; idle(4);
        rd(3'd4, 2'd0); check("R2 disabled no latch", rdata, 32'h00);
        pf_in = 1'b0; idle(4);

        // R3 terminal count
        wr(3'd3, 2'd0, 32'hFF); check("R3 tc high", {31'd0, tc_pulse}, 32'd1);
        idle(1); check("R3 tc one cycle", {31'd0, tc_pulse}, 32'd0);
        rd(3'd3, 2'd0); check("R3 bit1 not stored", rdata, 32'hFD);

        // R6 system control
        wr(3'd6, 2'd2, 32'hFFFF_FFFE); check("R6 no req", {31'd0, sys_reset_req}, 32'd0);
        rd(3'd6, 2'd2); check("R6 bit0 clear no effect", rdata, 32'd0);
        wr(3'd6, 2'd2, 32'h1); check("R6 req pulse", {31'd0, sys_reset_req}, 32'd1);
        rd(3'd6, 2'd2); check("R6 flag set", rdata, 32'h02);

        // R7 reset retention
        wr(3'd1, 2'd0, 32'h5A); wr(3'd2, 2'd0, 32'h33);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        rd(3'd1, 2'd0); check("R7 diag kept", rdata, 32'h5A);
        rd(3'd5, 2'd1); check("R7 led kept", rdata, 32'hBEEF);
        rd(3'd6, 2'd2); check("R7 sysctl kept", rdata, 32'h02);
        rd(3'd2, 2'd0); check("R7 modem cleared", rdata, 32'h00);
        rd(3'd3, 2'd0); check("R7 aux cleared", rdata, 32'h00);

        // R10 offset
        cyc(3'd0, 2'd0, 2'd1, 1'b1, 1'b0, 32'hFF);
        check("R10 no err", {31'd0, size_err}, 32'd0);
        rd(3'd0, 2'd0); check("R10 write ignored", rdata, 32'h00);
        cyc(3'd5, 2'd1, 2'd2, 1'b0, 1'b1, 32'd0); check("R10 read zero", rdata, 32'd0);
        // R11 unused select
        rd(3'd7, 2'd0); check("R11 select 7 zero", rdata, 32'd0);

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            logic [2:0] s; logic [1:0] z, o; logic w, r;
            rst_n = ($urandom % 400) != 0;
            if (($urandom % 16) == 0) pf_in = ~pf_in;
            s = 3'($urandom % 8);
            z = (($urandom % 4) != 0) ? need_size(s) : 2'($urandom % 4);
            o = (($urandom % 8) != 0) ? 2'd0 : 2'($urandom % 4);
            w = rst_n && (($urandom % 2) == 0);
            r = !w && (($urandom % 3) != 0);
            if (s == 3'd6 && w && ($urandom % 4) != 0) w = 1'b0;
            cyc(s, z, o, w, r, $urandom);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule